// File: doc/BRIEF.md
# Dual Alias Table Register Renamer

This unit renames micro-ops for an out-of-order core. Each cycle it can accept one micro-op that names two architectural source registers and one architectural destination. It returns the physical tags for both sources, a freshly allocated physical tag for the destination, and the physical tag the destination was mapped to before. The renamed micro-op carries that old tag until it commits. The architectural register space is mapped onto a larger pool of physical registers.

Two alias tables hold the mappings. The speculative table is written when a micro-op is renamed. The committed table is written when a micro-op retires. Retirement changes only a mapping, so no register values are moved. A bit-per-register free pool supplies new tags. On retirement, the tag that the committed table held for that destination goes back into the pool. A flush makes the speculative table a copy of the committed table in one cycle. The same flush rebuilds the pool from every tag that the committed table does not reference.

Top module: `dual_rat_renamer`

## Requirements
- R1: After reset both tables map architectural register i to physical tag i. Tags 8 to 127 are free, `ren_ready` is 1 and `out_valid` is 0.
- R2: An accepted micro-op reports its results on the cycle after acceptance, with `out_valid` high for exactly that cycle. The source tags are the speculative mappings before this micro-op's own write, and `out_old_tag` is the speculative mapping its destination held before.
- R3: The new destination tag is the lowest-numbered free physical tag. That tag leaves the pool.
- R4: A source equal to the same micro-op's destination reads the prior mapping. A micro-op in the next cycle reads the tag just allocated, with no gap.
- R5: `ren_ready` is 0 whenever the pool is empty. A micro-op offered then is not accepted, produces no output and does not change the speculative table.
- R6: Starting from a full pool, 120 micro-ops are accepted with no retirement before rename stalls.
- R7: On retirement the committed table takes `ret_tag` for `ret_dst`. The tag it held before returns to the pool and can be allocated from the next cycle on.
- R8: Retirement leaves the speculative table unchanged.
- R9: After a flush cycle, every speculative mapping equals the committed mapping, and that committed mapping includes a retirement in the flush cycle.
- R10: A flush rebuilds the pool to exactly the tags not referenced by the committed table, so 120 renames are accepted afterwards before a stall.
- R11: While `flush` is high, `ren_ready` is 0 and an offered micro-op is dropped.
- R12: A retirement and a flush in the same cycle both take effect. The retired tag stays mapped and the tag it replaced is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | A micro-op is offered for rename |
| ren_ready | output | 1 | Rename can accept this cycle |
| ren_src_a | input | 3 | First architectural source |
| ren_src_b | input | 3 | Second architectural source |
| ren_dst | input | 3 | Architectural destination |
| ret_valid | input | 1 | A micro-op commits this cycle |
| ret_dst | input | 3 | Architectural destination of the committing micro-op |
| ret_tag | input | 7 | Physical tag of the committing micro-op |
| flush | input | 1 | Discard speculative state |
| out_valid | output | 1 | Rename result valid |
| out_src_a_tag | output | 7 | Physical tag of the first source |
| out_src_b_tag | output | 7 | Physical tag of the second source |
| out_dst_tag | output | 7 | Newly allocated destination tag |
| out_old_tag | output | 7 | Prior speculative mapping of the destination |

## Verification
The sensitive overlap is a commit and a flush arriving in the same cycle. The committed table must take the new tag before it is copied into the speculative table. The pool must be rebuilt from that updated table and not from the stale one. The bench provokes this in random traffic, where flushes land on cycles that also carry commits. It also forces the case directly when many micro-ops are in flight. A reference model then checks every source tag read after the flush, and checks that exactly 120 further renames are accepted before a stall.

// File: rtl/renamer_pkg.sv
package renamer_pkg;
  localparam int unsigned RN_ARCH_REGS = 8;
  localparam int unsigned RN_PHYS_REGS = 128;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int unsigned NE = renamer_pkg::RN_ARCH_REGS,
  parameter int unsigned NP = renamer_pkg::RN_PHYS_REGS,
  localparam int unsigned IW = $clog2(NE),
  localparam int unsigned TW = $clog2(NP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [TW-1:0]     wr_tag,
  input  logic              load_en,
  input  logic [NE*TW-1:0]  load_flat,
  output logic [NE*TW-1:0]  map_flat,
  output logic [NE*TW-1:0]  next_flat
);
  for (genvar g = 0; g < NE; g++) begin : g_ent
    logic [TW-1:0] ent_q;
    logic [TW-1:0] ent_d;

    always_comb begin
      if (load_en)
        ent_d = load_flat[g*TW +: TW];
      else if (wr_en && (wr_idx == IW'(g)))
        ent_d = wr_tag;
      else
        ent_d = ent_q;
    end

    always_ff @(posedge clk) begin
      if (rst) ent_q <= TW'(g);
      else     ent_q <= ent_d;
    end

    assign map_flat[g*TW +: TW]  = ent_q;
    assign next_flat[g*TW +: TW] = ent_d;
  end
endmodule

// File: rtl/rn_use_mask.sv
module rn_use_mask #(
  parameter int unsigned NE = renamer_pkg::RN_ARCH_REGS,
  parameter int unsigned NP = renamer_pkg::RN_PHYS_REGS,
  localparam int unsigned TW = $clog2(NP)
) (
  input  logic [NE*TW-1:0] map_flat,
  output logic [NP-1:0]    used
);
  always_comb begin
    used = '0;
    for (int e = 0; e < NE; e++) used[map_flat[e*TW +: TW]] = 1'b1;
  end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int unsigned NE = renamer_pkg::RN_ARCH_REGS,
  parameter int unsigned NP = renamer_pkg::RN_PHYS_REGS,
  localparam int unsigned TW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_en,
  input  logic          rel_en,
  input  logic [TW-1:0] rel_tag,
  input  logic          rebuild_en,
  input  logic [NP-1:0] rebuild_free,
  output logic [TW-1:0] alloc_tag,
  output logic          any_free,
  output logic [NP-1:0] free_map
);
  logic [NP-1:0] free_q;
  logic [NP-1:0] take_oh;
  logic [NP-1:0] give_oh;

  // lowest-numbered free tag wins
  always_comb begin
    alloc_tag = '0;
    for (int i = NP - 1; i >= 0; i--)
      if (free_q[i]) alloc_tag = TW'(i);
  end

  assign any_free = |free_q;
  assign take_oh  = alloc_en ? ({{(NP-1){1'b0}}, 1'b1} << alloc_tag) : '0;
  assign give_oh  = rel_en   ? ({{(NP-1){1'b0}}, 1'b1} << rel_tag)   : '0;
  assign free_map = free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= int'(NE));
    end else if (rebuild_en) begin
      free_q <= rebuild_free;
    end else begin
      free_q <= (free_q & ~take_oh) | give_oh;
    end
  end

  AST_TAKEN_LEAVES_POOL: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> !free_q[$past(alloc_tag)]); // R3
  AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> !free_q[rel_tag]); // R7
endmodule

// File: rtl/dual_rat_renamer.sv
module dual_rat_renamer #(
  parameter int unsigned NUM_ARCH = renamer_pkg::RN_ARCH_REGS,
  parameter int unsigned NUM_PHYS = renamer_pkg::RN_PHYS_REGS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned TW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_dst,
  input  logic [TW-1:0] ret_tag,
  input  logic          flush,
  output logic          out_valid,
  output logic [TW-1:0] out_src_a_tag,
  output logic [TW-1:0] out_src_b_tag,
  output logic [TW-1:0] out_dst_tag,
  output logic [TW-1:0] out_old_tag
);
  localparam int unsigned FLAT_W = NUM_ARCH * TW;

  logic [FLAT_W-1:0]   spec_map, spec_next;
  logic [FLAT_W-1:0]   comm_map, comm_next;
  logic [NUM_PHYS-1:0] comm_used, free_map;
  logic [TW-1:0]       new_tag;
  logic                pool_has;
  logic                accept;

  assign ren_ready = pool_has && !flush;
  assign accept    = ren_valid && ren_ready;

  rn_alias_table #(.NE(NUM_ARCH), .NP(NUM_PHYS)) u_spec_tbl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (accept),
    .wr_idx    (ren_dst),
    .wr_tag    (new_tag),
    .load_en   (flush),
    .load_flat (comm_next),
    .map_flat  (spec_map),
    .next_flat (spec_next)
  );

  rn_alias_table #(.NE(NUM_ARCH), .NP(NUM_PHYS)) u_comm_tbl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ret_valid),
    .wr_idx    (ret_dst),
    .wr_tag    (ret_tag),
    .load_en   (1'b0),
    .load_flat ({FLAT_W{1'b0}}),
    .map_flat  (comm_map),
    .next_flat (comm_next)
  );

  rn_use_mask #(.NE(NUM_ARCH), .NP(NUM_PHYS)) u_mask (
    .map_flat (comm_next),
    .used     (comm_used)
  );

  rn_free_pool #(.NE(NUM_ARCH), .NP(NUM_PHYS)) u_pool (
    .clk          (clk),
    .rst          (rst),
    .alloc_en     (accept),
    .rel_en       (ret_valid),
    .rel_tag      (comm_map[ret_dst*TW +: TW]),
    .rebuild_en   (flush),
    .rebuild_free (~comm_used),
    .alloc_tag    (new_tag),
    .any_free     (pool_has),
    .free_map     (free_map)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_src_a_tag <= '0;
      out_src_b_tag <= '0;
      out_dst_tag   <= '0;
      out_old_tag   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_src_a_tag <= spec_map[ren_src_a*TW +: TW];
        out_src_b_tag <= spec_map[ren_src_b*TW +: TW];
        out_dst_tag   <= new_tag;
        out_old_tag   <= spec_map[ren_dst*TW +: TW];
      end
    end
  end

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!out_valid && $stable(out_dst_tag))); // R2
  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!accept && !flush) |-> (spec_next == spec_map)); // R5
  AST_FLUSH_COPIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (spec_map == comm_map)); // R9
  AST_REBUILD_COUNT: assert property (@(posedge clk) disable iff (rst)
    flush |=> ($countones(free_map) == int'(NUM_PHYS - NUM_ARCH))); // R10
endmodule

// File: tb/dual_rat_renamer_tb.sv
`timescale 1ns/1ps
module dual_rat_renamer_tb_top;
  localparam int NA = 8;
  localparam int NP = 128;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ren_valid = 1'b0;
  logic       ren_ready;
  logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
  logic       ret_valid = 1'b0;
  logic [2:0] ret_dst = '0;
  logic [6:0] ret_tag = '0;
  logic       flush = 1'b0;
  logic       out_valid;
  logic [6:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag;

  always #10 clk = ~clk;

  dual_rat_renamer dut_i (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ret_valid(ret_valid), .ret_dst(ret_dst), .ret_tag(ret_tag), .flush(flush),
    .out_valid(out_valid), .out_src_a_tag(out_src_a_tag),
    .out_src_b_tag(out_src_b_tag), .out_dst_tag(out_dst_tag),
    .out_old_tag(out_old_tag)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  int spec_m[NA];
  int comm_m[NA];
  bit free_m[NP];
  int q_d[NP];
  int q_t[NP];
  int qh = 0, qt = 0, qcnt = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < NP; i++) if (free_m[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin spec_m[i] = i; comm_m[i] = i; end
    for (int i = 0; i < NP; i++) free_m[i] = (i >= NA);
    qh = 0; qt = 0; qcnt = 0;
  endtask

  // called at a negedge; checks the result one clock later
  task automatic step(input bit rv, input int a, input int b, input int d,
                      input bit rq, input bit fl, input string lab);
    bit exp_ready, acc, rt_v;
    int ea, eb, ed, eo, rd, rt, old;
    rt_v = rq && (qcnt > 0);
    rd = 0; rt = 0;
    if (rt_v) begin
      rd = q_d[qh]; rt = q_t[qh];
      qh = (qh + 1) % NP; qcnt--;
    end
    ren_valid = rv; ren_src_a = 3'(a); ren_src_b = 3'(b); ren_dst = 3'(d);
    ret_valid = rt_v; ret_dst = 3'(rd); ret_tag = 7'(rt); flush = fl;
    #1;
    exp_ready = (low_free() >= 0) && !fl;
    chk(lab, "ren_ready", int'(ren_ready), int'(exp_ready));
    acc = rv && exp_ready;
    ea = spec_m[a]; eb = spec_m[b]; eo = spec_m[d]; ed = low_free();
    if (rt_v) begin
      old = comm_m[rd];
      comm_m[rd] = rt;
      free_m[old] = 1'b1;
    end
    if (acc) begin
      free_m[ed] = 1'b0;
      spec_m[d] = ed;
      q_d[qt] = d; q_t[qt] = ed; qt = (qt + 1) % NP; qcnt++;
    end
    if (fl) begin
      for (int i = 0; i < NP; i++) free_m[i] = 1'b1;
      for (int i = 0; i < NA; i++) begin
        spec_m[i] = comm_m[i];
        free_m[comm_m[i]] = 1'b0;
      end
      qh = 0; qt = 0; qcnt = 0;
    end
    @(posedge clk);
    @(negedge clk);
    ren_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0;
    chk(lab, "out_valid", int'(out_valid), int'(acc));
    if (acc) begin
      chk(lab, "src_a_tag", int'(out_src_a_tag), ea);
      chk(lab, "src_b_tag", int'(out_src_b_tag), eb);
      chk(lab, "dst_tag", int'(out_dst_tag), ed);
      chk(lab, "old_tag", int'(out_old_tag), eo);
    end
  endtask

  function automatic int rnd(input int m);
    return int'($urandom % 32'(m));
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired, all requirements actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "ren_ready", int'(ren_ready), 1);
    step(1, 3, 5, 2, 0, 0, "R1");
    step(1, 7, 0, 6, 0, 0, "R1");
    // R4: back-to-back dependency and source equal to own destination
    step(1, 2, 2, 2, 0, 0, "R4");
    step(1, 2, 6, 0, 0, 0, "R4");
    // R8: retirement does not disturb the speculative table
    step(1, 1, 0, 4, 1, 0, "R8");
    step(1, 2, 6, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 0, "R7");
    // random traffic, flushes may coincide with retirement (R12)
    for (int n = 0; n < 2500; n++)
      step(rnd(10) < 7, rnd(NA), rnd(NA), rnd(NA), rnd(10) < 4, rnd(100) < 2,
           "R2 R3 R12");
    // R9: flush then read every mapping
    step(0, 0, 0, 0, 1, 1, "R9");
    for (int i = 0; i < NA; i++) step(1, i, (i + 3) % NA, i, 0, 0, "R9");
    // R6: capacity from a full pool
    step(0, 0, 0, 0, 0, 1, "R6");
    for (int n = 0; n < 120; n++) step(1, rnd(NA), rnd(NA), rnd(NA), 0, 0, "R6");
    // R5: stall when empty
    step(1, 1, 2, 3, 0, 0, "R5");
    step(1, 4, 5, 6, 0, 0, "R5");
    // R7: a retire refills an empty pool for the next cycle
    step(1, 0, 1, 2, 1, 0, "R7");
    step(1, 3, 4, 5, 0, 0, "R7");
    step(1, 3, 4, 5, 0, 0, "R7");
    for (int n = 0; n < 10; n++) step(0, 0, 0, 0, 1, 0, "R7");
    // R12: retire and flush in one cycle, then R10 rebuilt capacity
    step(1, 2, 3, 4, 1, 1, "R12");
    for (int i = 0; i < NA; i++) step(1, i, i, (i + 1) % NA, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 1, "R10");
    for (int n = 0; n < 121; n++) step(1, rnd(NA), rnd(NA), rnd(NA), 0, 0, "R10");
    // R11: rename offered during flush is dropped
    step(1, 1, 1, 1, 0, 1, "R11");
    step(1, 1, 2, 3, 0, 0, "R11");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule